// File: doc/BRIEF.md
# Sampled Phase-Frequency Detector

This block compares the timing of two single-bit square waves in a fully clocked phase-locked loop. One input is the reference. The other is the divided oscillator feedback. The block keeps one sticky flag for each input. A flag is set on that input's rising edge. When both flags would be set together, both are dropped.

On every sample clock the block turns the flag state into a signed fixed-point error word. The word has 14 fractional bits and takes one of three values: a positive unit asks the loop filter to raise the oscillator frequency, a negative unit asks it to lower it, and zero asks it to hold. The word feeds a discrete-time loop filter directly, so no charge pump is needed.

Each input is registered once. An edge is recognised when the registered sample is 1 and the sample before it was 0. As a result, the error word follows an input rise by two sample clocks.

Top module: `pfd_err`

## Requirements
- R1: While `rst` is high at a clock edge, both flags and the input history are cleared, and `err_out` reads 0 after that edge.
- R2: Only a rising edge (a 0 sample followed by a 1 sample) acts on a flag. A level held high, a falling edge, or a low level leaves `err_out` unchanged.
- R3: A reference rise with no feedback flag pending drives `err_out` to +1.0 (16'h4000). The new value appears two clocks after the input rise is first sampled, and it holds until a feedback edge arrives.
- R4: A feedback rise with no reference flag pending drives `err_out` to -1.0 (16'hC000). It holds until a reference edge arrives.
- R5: An edge on the opposite input while a drive is active clears both flags, and `err_out` returns to 0 on the next clock.
- R6: Rising edges on both inputs in the same sample give `err_out` = 0 and leave both flags clear.
- R7: `err_out` only ever takes the values 16'h0000, 16'h4000 and 16'hC000.
- R8: Further edges on the input that already owns the active drive keep the same drive value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference square wave |
| fb_in | input | 1 | Feedback square wave from the oscillator divider |
| err_out | output | 16 | Signed Q2.14 phase error: +1.0, -1.0 or 0 |

## Verification
Directed sequences show a reference lead and a feedback lead apart. Each is followed by the opposite edge, which shows the drive returning to zero. Coincident rises are applied both from idle and while a drive is active, so the clear-both path is checked. Long high levels and repeated same-side edges check that levels are ignored and that a drive stays sticky. A seeded random stream with varied toggle densities then compares every sample against a bench model built from the requirements.

// File: rtl/pfd_err.sv
module pfd_err #(
  parameter int W    = 16,
  parameter int FRAC = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ref_in,
  input  logic                fb_in,
  output logic signed [W-1:0] err_out
);

  localparam logic signed [W-1:0] POS  = W'(1) << FRAC;
  localparam logic signed [W-1:0] NEG  = -POS;
  localparam logic signed [W-1:0] ZERO = '0;

  logic ref_q, ref_p, fb_q, fb_p;
  logic up, dn;
  logic ref_edge, fb_edge;
  logic up_nx, dn_nx, clr;

  assign ref_edge = ref_q & ~ref_p;
  assign fb_edge  = fb_q & ~fb_p;
  assign up_nx    = up | ref_edge;
  assign dn_nx    = dn | fb_edge;
  assign clr      = ~(~(up_nx & dn_nx));

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= 1'b0;
      ref_p <= 1'b0;
      fb_q  <= 1'b0;
      fb_p  <= 1'b0;
      up    <= 1'b0;
      dn    <= 1'b0;
    end else begin
      ref_q <= ref_in;
      ref_p <= ref_q;
      fb_q  <= fb_in;
      fb_p  <= fb_q;
      up    <= up_nx & ~clr;
      dn    <= dn_nx & ~clr;
    end
  end

  assign err_out = up ? POS : (dn ? NEG : ZERO);

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> err_out == ZERO);
  a_r7_legal: assert property (@(posedge clk) disable iff (rst)
    (err_out == ZERO) || (err_out == POS) || (err_out == NEG));
  a_r2_no_edge_hold: assert property (@(posedge clk) disable iff (rst)
    (!ref_edge && !fb_edge) |=> $stable(err_out));
  a_r3_lead_up: assert property (@(posedge clk) disable iff (rst)
    (ref_edge && !fb_edge && !dn) |=> err_out == POS);
  a_r4_lead_dn: assert property (@(posedge clk) disable iff (rst)
    (fb_edge && !ref_edge && !up) |=> err_out == NEG);
  a_r5_clear: assert property (@(posedge clk) disable iff (rst)
    ((up && fb_edge) || (dn && ref_edge)) |=> err_out == ZERO);
  a_r6_coincident: assert property (@(posedge clk) disable iff (rst)
    (ref_edge && fb_edge) |=> err_out == ZERO);

endmodule

// File: tb/pfd_err_tb.sv
module pfd_err_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_in = 1'b0;
  logic fb_in = 1'b0;
  logic signed [15:0] err_out;

  int n_cmp = 0;
  int n_bad = 0;

  logic mq_r, mp_r, mq_f, mp_f, mu, md;

  always #2.5 clk = ~clk;

  pfd_err u_dut (.clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .err_out(err_out));

  function automatic logic [15:0] expect_err(input logic u, input logic d);
    return u ? 16'h4000 : (d ? 16'hC000 : 16'h0000);
  endfunction

  task automatic model_step(input logic r, input logic f, input logic rs);
    logic er, ef, nu, nd;
    if (rs) begin
      mq_r = 0; mp_r = 0; mq_f = 0; mp_f = 0; mu = 0; md = 0;
    end else begin
      er = mq_r & ~mp_r;
      ef = mq_f & ~mp_f;
      nu = mu | er;
      nd = md | ef;
      if (nu && nd) begin nu = 0; nd = 0; end
      mu = nu; md = nd;
      mp_r = mq_r; mq_r = r;
      mp_f = mq_f; mq_f = f;
    end
  endtask

  task automatic cyc(input logic r, input logic f, input string tag);
    logic [15:0] exp;
    ref_in = r;
    fb_in = f;
    @(posedge clk);
    model_step(r, f, rst);
    @(negedge clk);
    exp = expect_err(mu, md);
    n_cmp++;
    if (err_out !== exp) begin
      n_bad++;
      $display("FAIL %s: err_out actual %h expected %h", tag, err_out, exp);
    end
  endtask

  task automatic check_val(input logic [15:0] exp, input string tag);
    n_cmp++;
    if (err_out !== exp) begin
      n_bad++;
      $display("FAIL %s: err_out actual %h expected %h", tag, err_out, exp);
    end
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(1234);
    mq_r = 0; mp_r = 0; mq_f = 0; mp_f = 0; mu = 0; md = 0;
    @(negedge clk);
    rst = 1;
    cyc(1, 1, "R1");
    cyc(1, 0, "R1");
    check_val(16'h0000, "R1");
    rst = 0;
    for (int i = 0; i < 3; i++) cyc(0, 0, "R2");
    // R3: reference leads; +1.0 appears two clocks after the rise
    cyc(1, 0, "R3");
    check_val(16'h0000, "R3");
    cyc(1, 0, "R3");
    check_val(16'h4000, "R3");
    for (int i = 0; i < 4; i++) cyc(i[0], 0, "R8");
    check_val(16'h4000, "R8");
    cyc(0, 0, "R2");
    for (int i = 0; i < 4; i++) cyc(1, 0, "R2");
    // R5: feedback edge clears the drive
    cyc(1, 1, "R5");
    cyc(1, 1, "R5");
    check_val(16'h0000, "R5");
    cyc(0, 0, "R2");
    cyc(0, 0, "R2");
    // R4: feedback leads
    cyc(0, 1, "R4");
    cyc(0, 1, "R4");
    check_val(16'hC000, "R4");
    cyc(0, 0, "R2");
    check_val(16'hC000, "R2");
    cyc(0, 1, "R8");
    cyc(0, 1, "R8");
    check_val(16'hC000, "R8");
    cyc(1, 1, "R5");
    cyc(1, 1, "R5");
    check_val(16'h0000, "R5");
    cyc(0, 0, "R6");
    // R6: coincident edges from idle
    cyc(1, 1, "R6");
    cyc(1, 1, "R6");
    check_val(16'h0000, "R6");
    cyc(1, 1, "R6");
    check_val(16'h0000, "R6");
    cyc(0, 0, "R6");
    cyc(1, 0, "R3");
    cyc(0, 0, "R3");
    check_val(16'h4000, "R3");
    // R6 while up: ref and fb rise together, clear
    cyc(1, 1, "R6");
    cyc(0, 0, "R6");
    check_val(16'h0000, "R6");
    cyc(0, 0, "R6");
    // R1 mid-run
    cyc(0, 1, "R1");
    cyc(0, 0, "R1");
    rst = 1;
    cyc(0, 0, "R1");
    check_val(16'h0000, "R1");
    rst = 0;
    // random, varied toggle density
    for (int blk = 0; blk < 8; blk++) begin
      int dens = 1 + blk;
      logic r = 0, f = 0;
      for (int i = 0; i < 600; i++) begin
        if (($urandom % 10) < dens) r = ~r;
        if (($urandom % 10) < dens) f = ~f;
        cyc(r, f, "R7");
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule